// File: doc/BRIEF.md
# Cursor Limit Detector with Margin Bell

This block sits beside the column and row cursor counters of a character display. It watches the column count, which runs 0 to 79, and the row count, which runs 0 to 23. From them it decodes four limit flags: first column, last column, top row and bottom row. The counters use these flags to decide when to wrap or stop. The flags are not followed combinationally. They are captured into a register only when the timing strobe `sample` is high, so they stay steady while the counters change between strobes.

The block also produces a one-cycle `bell` pulse when the cursor steps forward across the right margin. The margin step is a column count of 71 in one cycle followed by 72 in the next cycle (character positions 72 and 73, counted from one). A later stage turns this pulse into sound. Sound generation and the counters themselves are outside this block.

Top module: `cursor_limit_detector`

## Requirements
- R1: While `rst` is high at a rising edge, all four flags and `bell` are 0 after that edge, whatever `sample` and the counts are.
- R2: On a rising edge with `sample` high, `col_first` becomes 1 if `col_cnt` is 0 and becomes 0 otherwise.
- R3: On a rising edge with `sample` high, `col_last` becomes 1 if `col_cnt` is 79 and becomes 0 otherwise.
- R4: On a rising edge with `sample` high, `row_first` becomes 1 if `row_cnt` is 0 and becomes 0 otherwise.
- R5: On a rising edge with `sample` high, `row_last` becomes 1 if `row_cnt` is 23 and becomes 0 otherwise.
- R6: On a rising edge with `sample` low, all four flags keep their values, even if the counts change.
- R7: When `col_cnt` is 71 at one rising edge and 72 at the next rising edge, `bell` is 1 for exactly the cycle after that second edge. `sample` has no effect on this.
- R8: `bell` stays 0 when `col_cnt` reaches 72 from any value other than 71. This covers a backward step from 73, a load from a distant column, and holding at 72.
- R9: `bell` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 1 | Strobe that captures the limit flags |
| col_cnt | input | 7 | Current column count, 0 to 79 |
| row_cnt | input | 5 | Current row count, 0 to 23 |
| col_first | output | 1 | Registered flag: column count was 0 |
| col_last | output | 1 | Registered flag: column count was 79 |
| row_first | output | 1 | Registered flag: row count was 0 |
| row_last | output | 1 | Registered flag: row count was 23 |
| bell | output | 1 | One-cycle margin-crossing pulse |

## Verification
The margin pulse is the hardest case to reach from the ports. It needs exactly 71 followed by 72 on consecutive edges, and uniform random column values almost never produce that pair. The stimulus therefore weights the column draw towards 0, 71, 72, 73 and 79, and after a 71 it often forces the next column to 72. Directed sequences add the three near-misses that must stay silent: a backward step from 73, a jump from column 10, and holding at 72. The strobe is also randomized, so flag holding is tested while the counts keep changing underneath it.

// File: rtl/cld_pkg.sv
package cld_pkg;

  typedef struct packed {
    logic col_first;
    logic col_last;
    logic row_first;
    logic row_last;
  } cld_flags_t;

  localparam cld_flags_t CLD_FLAGS_CLEAR = '{default: 1'b0};

endpackage

// File: rtl/cld_axis_decode.sv
module cld_axis_decode #(
  parameter int COUNT_W = 7,
  parameter int LAST_VAL = 79
) (
  input  logic [COUNT_W-1:0] cnt,
  output logic               at_first,
  output logic               at_last
);

  localparam logic [COUNT_W-1:0] FIRST_C = '0;
  localparam logic [COUNT_W-1:0] LAST_C  = COUNT_W'(LAST_VAL);

  always_comb begin
    at_first = (cnt == FIRST_C);
    at_last  = (cnt == LAST_C);
  end

endmodule

// File: rtl/cld_flag_reg.sv
module cld_flag_reg
  import cld_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  cld_flags_t d,
  output cld_flags_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CLD_FLAGS_CLEAR;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cld_margin_bell.sv
module cld_margin_bell #(
  parameter int COUNT_W = 7,
  parameter int TRIP_COL = 72
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] cnt,
  output logic               bell
);

  localparam logic [COUNT_W-1:0] TRIP_C = COUNT_W'(TRIP_COL);
  localparam logic [COUNT_W-1:0] PRE_C  = COUNT_W'(TRIP_COL - 1);

  logic [COUNT_W-1:0] prev_cnt;
  logic               step_over;

  assign step_over = (prev_cnt == PRE_C) && (cnt == TRIP_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cnt <= '0;
      bell     <= 1'b0;
    end else begin
      prev_cnt <= cnt;
      bell     <= step_over;
    end
  end

endmodule

// File: rtl/cursor_limit_detector.sv
module cursor_limit_detector
  import cld_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 24,
  parameter int BELL_COL = 72
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample,
  input  logic [$clog2(COLS)-1:0]  col_cnt,
  input  logic [$clog2(ROWS)-1:0]  row_cnt,
  output logic                     col_first,
  output logic                     col_last,
  output logic                     row_first,
  output logic                     row_last,
  output logic                     bell
);

  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  cld_flags_t flags_d;
  cld_flags_t flags_q;

  cld_axis_decode #(.COUNT_W(CW), .LAST_VAL(COLS - 1)) u_col_dec (
    .cnt      (col_cnt),
    .at_first (flags_d.col_first),
    .at_last  (flags_d.col_last)
  );

  cld_axis_decode #(.COUNT_W(RW), .LAST_VAL(ROWS - 1)) u_row_dec (
    .cnt      (row_cnt),
    .at_first (flags_d.row_first),
    .at_last  (flags_d.row_last)
  );

  cld_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (sample),
    .d    (flags_d),
    .q    (flags_q)
  );

  cld_margin_bell #(.COUNT_W(CW), .TRIP_COL(BELL_COL)) u_bell (
    .clk  (clk),
    .rst  (rst),
    .cnt  (col_cnt),
    .bell (bell)
  );

  assign col_first = flags_q.col_first;
  assign col_last  = flags_q.col_last;
  assign row_first = flags_q.row_first;
  assign row_last  = flags_q.row_last;

endmodule

// File: rtl/cld_checker.sv
module cld_checker #(
  parameter int COLS = 80,
  parameter int ROWS = 24,
  parameter int BELL_COL = 72
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sample,
  input logic [$clog2(COLS)-1:0]  col_cnt,
  input logic [$clog2(ROWS)-1:0]  row_cnt,
  input logic                     col_first,
  input logic                     col_last,
  input logic                     row_first,
  input logic                     row_last,
  input logic                     bell
);

  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] TRIP_C   = CW'(BELL_COL);
  localparam logic [CW-1:0] PRE_C    = CW'(BELL_COL - 1);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !col_first && !col_last && !row_first && !row_last && !bell); // R1

  AST_COL_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    sample |=> col_first == ($past(col_cnt) == '0)); // R2

  AST_COL_LAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    sample |=> col_last == ($past(col_cnt) == LAST_COL)); // R3

  AST_ROW_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    sample |=> row_first == ($past(row_cnt) == '0)); // R4

  AST_ROW_LAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    sample |=> row_last == ($past(row_cnt) == LAST_ROW)); // R5

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample |=> $stable({col_first, col_last, row_first, row_last})); // R6

  AST_BELL_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) && ($past(col_cnt, 2) == PRE_C) && ($past(col_cnt) == TRIP_C)
      |-> bell); // R7

  AST_BELL_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    bell |-> (age >= 2'd2) && ($past(col_cnt, 2) == PRE_C) && ($past(col_cnt) == TRIP_C)); // R8

  AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bell |=> !bell); // R9

endmodule

bind cursor_limit_detector cld_checker #(
  .COLS(COLS), .ROWS(ROWS), .BELL_COL(BELL_COL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample    (sample),
  .col_cnt   (col_cnt),
  .row_cnt   (row_cnt),
  .col_first (col_first),
  .col_last  (col_last),
  .row_first (row_first),
  .row_last  (row_last),
  .bell      (bell)
);

// File: tb/cursor_limit_detector_tb.sv
module cursor_limit_detector_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample = 1'b0;
  logic [6:0] col_cnt = '0;
  logic [4:0] row_cnt = '0;
  logic       col_first, col_last, row_first, row_last, bell;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic e_cf, e_cl, e_rf, e_rl, e_bell;
  int   prev_col;

  always #4 clk = ~clk;

  cursor_limit_detector u_dut (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample),
    .col_cnt   (col_cnt),
    .row_cnt   (row_cnt),
    .col_first (col_first),
    .col_last  (col_last),
    .row_first (row_first),
    .row_last  (row_last),
    .bell      (bell)
  );

  function automatic logic bell_due(input int p, input int c);
    return (p == 71) && (c == 72);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model at the rising edge, compare just after it.
  task automatic step(input logic s, input int c, input int r);
    @(negedge clk);
    sample  = s;
    col_cnt = 7'(c);
    row_cnt = 5'(r);
    @(posedge clk);
    if (rst) begin
      e_cf = 0; e_cl = 0; e_rf = 0; e_rl = 0; e_bell = 0; prev_col = 0;
    end else begin
      if (s) begin
        e_cf = (c == 0); e_cl = (c == 79); e_rf = (r == 0); e_rl = (r == 23);
      end
      e_bell   = bell_due(prev_col, c);
      prev_col = c;
    end
    #1;
    if (rst) begin
      check("R1", col_first | col_last | row_first | row_last | bell, 1'b0);
    end else begin
      check(s ? "R2" : "R6", col_first, e_cf);
      check(s ? "R3" : "R6", col_last,  e_cl);
      check(s ? "R4" : "R6", row_first, e_rf);
      check(s ? "R5" : "R6", row_last,  e_rl);
      check(e_bell ? "R7" : "R8", bell, e_bell);
    end
  endtask

  function automatic int pick_col(input int last);
    int k = int'($urandom_range(0, 9));
    if (last == 71 && k < 6) return 72;
    case (k)
      0: return 0;
      1: return 79;
      2: return 71;
      3: return 72;
      4: return 73;
      default: return int'($urandom_range(0, 79));
    endcase
  endfunction

  function automatic int pick_row();
    int k = int'($urandom_range(0, 5));
    case (k)
      0: return 0;
      1: return 23;
      default: return int'($urandom_range(0, 23));
    endcase
  endfunction

  initial begin
    int seed_dummy;
    int last_bell;
    seed_dummy = $urandom(20240611);
    // R1: reset with a strobe and counts that would otherwise set flags
    rst = 1'b1;
    step(1'b1, 0, 0);
    step(1'b1, 71, 23);
    rst = 1'b0;
    // R2/R4 capture at the first corner, R6 hold while counts move
    step(1'b1, 0, 0);
    step(1'b0, 79, 23);
    // R3/R5 at the far corner
    step(1'b1, 79, 23);
    step(1'b1, 40, 12);
    // R7 forward margin step
    step(1'b0, 70, 5);
    step(1'b0, 71, 5);
    step(1'b0, 72, 5);
    step(1'b0, 72, 5);   // R8 holding at 72, R9 single pulse
    // R8 backward from 73
    step(1'b1, 73, 5);
    step(1'b1, 72, 5);
    // R8 load from a distant column
    step(1'b0, 10, 5);
    step(1'b0, 72, 5);
    // R7 with strobe high
    step(1'b1, 71, 1);
    step(1'b1, 72, 22);
    // random mix
    last_bell = 0;
    for (int i = 0; i < 3000; i++) begin
      int c = pick_col(last_bell);
      step(1'($urandom_range(0, 1)), c, pick_row());
      last_bell = c;
    end
    // R1 mid-run reset after a margin step
    step(1'b0, 71, 0);
    rst = 1'b1;
    step(1'b1, 72, 0);
    rst = 1'b0;
    step(1'b0, 72, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule